// File: doc/BRIEF.md
# Reset Qualifier and Strap Configuration Unit

This unit sits between a board-level active-low reset line and the rest of a video encoder. It decides whether a low level on the reset line is a real reset or a glitch. For a real reset, it keeps an internal reset asserted for the whole low period and for a fixed number of clock cycles after the line returns high. During that window it holds every configurable pin in a safe direction. It also sends the serial control interface a one-cycle abort so that interface drops any transfer it was in the middle of.

At the end of the window the unit samples five strapping inputs through a synchroniser and loads them into configuration fields:

- video standard
- input format code
- demultiplex phase
- master/slave sync mode
- colour-bar enable

These defaults stay until a write through a simple address/data/enable port replaces a field. Writes that arrive while the internal reset is asserted are dropped. The straps are not sampled again until the next qualified reset.

Top module: `rst_strap_ctrl`

## Requirements
- R1: A low on `rst_n_raw` is taken as a reset only when it is sampled low on 2 consecutive rising clock edges. A single-cycle low pulse leaves `rst_int_n` high and every output unchanged.
- R2: `rst_int_n` goes low in the cycle after the second consecutive low sample. It stays low while `rst_n_raw` is low, and for 32 further cycles after the first edge that samples `rst_n_raw` high. The count restarts if a new reset qualifies during those 32 cycles.
- R3: `bus_abort` is high for exactly one cycle, in the first cycle of each qualified reset. It does not pulse again while the reset line stays low.
- R4: While `rst_int_n` is low, every pin-enable output is 0: `sync_oe`, `csync_oe`, `vsout_oe`, `ttx_oe` and `phase_oe`. Once the window ends, `csync_oe`, `vsout_oe` and `ttx_oe` are 1 and `phase_oe` stays 0.
- R5: The straps pass through a two-stage synchroniser. They are loaded on the clock edge where the 32-cycle count expires. `strap_std` is copied to `cfg_std` (0 = NTSC-M, 1 = PAL-B/G).
- R6: `strap_fmt` = 0 loads `cfg_fmt` = 0 (4:2:2 YCbCr). `strap_fmt` = 1 loads `cfg_fmt` = 3 (4:4:4 RGB).
- R7: `cfg_phase[0]` takes the level of `strap_ph_lsb` and `cfg_phase[1]` takes the level of `strap_ph_msb`.
- R8: `strap_master` loads `cfg_master`, and `cfg_cbar_en` is loaded with its inverse. `sync_oe` (bit 0 field sync, bit 1 vertical sync, bit 2 horizontal sync) is 3'b111 outside the reset window when `cfg_master` = 1, and 3'b000 otherwise.
- R9: A write with `wr_en` = 1 outside reset updates the addressed field from the next cycle onward:
  - address 0: `cfg_std` = data[0]
  - address 1: `cfg_fmt` = data[1:0]
  - address 2: `cfg_phase` = data[1:0]
  - address 3: `cfg_master` = data[0] and `cfg_cbar_en` = data[1]
  - any other address changes nothing
- R10: Writes made while `rst_int_n` is low change no field.
- R11: Strap changes outside a reset window have no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_raw | input | 1 | Unqualified active-low reset line |
| strap_std | input | 1 | Standard strap |
| strap_fmt | input | 1 | Input format strap |
| strap_ph_lsb | input | 1 | Demultiplex phase LSB strap |
| strap_ph_msb | input | 1 | Demultiplex phase MSB strap |
| strap_master | input | 1 | Master/slave strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 2 | Register write data |
| rst_int_n | output | 1 | Stretched internal reset, active low |
| bus_abort | output | 1 | One-cycle abort to serial control interface |
| cfg_std | output | 1 | Video standard field |
| cfg_fmt | output | 2 | Input format code |
| cfg_phase | output | 2 | Demultiplex phase {msb, lsb} |
| cfg_master | output | 1 | Sync master mode |
| cfg_cbar_en | output | 1 | Internal colour-bar enable |
| sync_oe | output | 3 | Output enables of the sync pins |
| csync_oe | output | 1 | Composite-sync output enable |
| vsout_oe | output | 1 | Vertical sync output enable |
| ttx_oe | output | 1 | Teletext request pin output enable |
| phase_oe | output | 1 | Demultiplex phase pin output enable |

## Verification
On every cycle the assertions check the following:
- the safe pin state whenever the internal reset is low;
- that the abort lasts a single cycle;
- that a lone low sample never drops the internal reset;
- that fields freeze across reset cycles and while no write arrives in normal operation;
- that sync enables stay off in slave mode.

Some behaviours only the bench scenarios can show, by comparing every output each cycle against a behavioural model:
- the exact 32-cycle stretch length;
- the restart of the window when a reset arrives mid-stretch;
- the strap-to-field encodings;
- the register map;
- that writes and strap changes are dropped at the right times.

// File: rtl/rsc_pkg.sv
// Package: shared types and constants for the reset/strap unit.
// Assumes: straps are packed LSB-first in the order listed below.
package rsc_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2
    } rst_state_e;

    typedef struct packed {
        logic       std;
        logic [1:0] fmt;
        logic [1:0] phase;
        logic       master;
        logic       cbar_en;
    } cfg_t;

    localparam int STRAP_W      = 5;
    localparam int SB_STD       = 0;
    localparam int SB_FMT       = 1;
    localparam int SB_PH_LSB    = 2;
    localparam int SB_PH_MSB    = 3;
    localparam int SB_MASTER    = 4;

    localparam logic [1:0] FMT_YCC422 = 2'd0;
    localparam logic [1:0] FMT_RGB444 = 2'd3;

    localparam int ADDR_STD   = 0;
    localparam int ADDR_FMT   = 1;
    localparam int ADDR_PHASE = 2;
    localparam int ADDR_MODE  = 3;

endpackage

// File: rtl/rsc_reset_qual.sv
// Module: qualifies the raw active-low reset and stretches it.
// A reset is recognised after MIN_LOW consecutive low samples. The internal
// reset then holds while the line is low and for STRETCH cycles after the
// first high sample. Emits a one-cycle abort on entry and a load strobe on
// the edge where the stretch expires.
// Assumes: MIN_LOW >= 2, STRETCH >= 2; the raw line is already synchronous
// or glitch-only (metastability is handled upstream).
module rsc_reset_qual
    import rsc_pkg::*;
#(
    parameter int MIN_LOW = 2,
    parameter int STRETCH = 32
) (
    input  logic clk,
    input  logic rst_n_raw,
    output logic rst_int_n,
    output logic load_cfg,
    output logic bus_abort
);

    localparam int HIST_W = (MIN_LOW > 1) ? MIN_LOW - 1 : 1;
    localparam int CNT_W  = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH - 1);

    logic [HIST_W-1:0] low_hist;
    logic              qualify;
    rst_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              abort_q;

    // Keep a history of the previous low samples of the raw line.
    generate
        if (HIST_W == 1) begin : g_hist1
            always_ff @(posedge clk) begin
                low_hist <= ~rst_n_raw;
            end
        end else begin : g_histn
            always_ff @(posedge clk) begin
                low_hist <= {low_hist[HIST_W-2:0], ~rst_n_raw};
            end
        end
    endgenerate

    // A reset qualifies when the current and all remembered samples are low.
    assign qualify = ~rst_n_raw & (&low_hist);

    // Sequence hold, stretch and run phases; restart on any new qualification.
    always_ff @(posedge clk) begin
        abort_q <= 1'b0;
        if (qualify) begin
            state   <= ST_HOLD;
            cnt     <= '0;
            abort_q <= (state != ST_HOLD);
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (rst_n_raw) begin
                        state <= ST_STRETCH;
                        cnt   <= '0;
                    end
                end
                ST_STRETCH: begin
                    if (cnt == CNT_LAST) begin
                        state <= ST_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_RUN;
                end
            endcase
        end
    end

    assign rst_int_n = (state == ST_RUN);
    assign load_cfg  = (state == ST_STRETCH) && (cnt == CNT_LAST) && !qualify;
    assign bus_abort = abort_q;

endmodule

// File: rtl/rsc_cfg_regs.sv
// Module: strap synchroniser and configuration register file.
// Straps pass through SYNC_STAGES flops and are loaded on load_cfg.
// Writes are accepted only while rst_int_n is high; an unknown address
// changes nothing.
// Assumes: load_cfg only ever fires while rst_int_n is low, so the two
// update sources never collide; DATA_W >= 2.
module rsc_cfg_regs
    import rsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 2
) (
    input  logic              clk,
    input  logic              rst_int_n,
    input  logic              load_cfg,
    input  logic [STRAP_W-1:0] strap_raw,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);

    logic [STRAP_W-1:0] sync_q [SYNC_STAGES];
    logic [STRAP_W-1:0] strap_s;
    logic               wr_ok;
    cfg_t               strap_cfg;

    // First synchroniser stage captures the asynchronous strap levels.
    always_ff @(posedge clk) begin
        sync_q[0] <= strap_raw;
    end

    // Remaining synchroniser stages.
    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    assign strap_s = sync_q[SYNC_STAGES-1];

    // Translate synchronised strap levels into field encodings.
    always_comb begin
        strap_cfg.std     = strap_s[SB_STD];
        strap_cfg.fmt     = strap_s[SB_FMT] ? FMT_RGB444 : FMT_YCC422;
        strap_cfg.phase   = {strap_s[SB_PH_MSB], strap_s[SB_PH_LSB]};
        strap_cfg.master  = strap_s[SB_MASTER];
        strap_cfg.cbar_en = ~strap_s[SB_MASTER];
    end

    assign wr_ok = wr_en && rst_int_n;

    // Update fields from the strap load or from an accepted write.
    always_ff @(posedge clk) begin
        if (load_cfg) begin
            cfg <= strap_cfg;
        end else if (wr_ok) begin
            unique case (int'(wr_addr))
                ADDR_STD:   cfg.std   <= wr_data[0];
                ADDR_FMT:   cfg.fmt   <= wr_data[1:0];
                ADDR_PHASE: cfg.phase <= wr_data[1:0];
                ADDR_MODE: begin
                    cfg.master  <= wr_data[0];
                    cfg.cbar_en <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rsc_pin_ctrl.sv
// Module: pin direction control.
// All enables are 0 while rst_int_n is low. Sync pins drive only in
// master mode outside reset. The composite/vertical outputs and the
// teletext request pin drive outside reset. The phase pin is a strap and
// stays an input.
// Assumes: master is a registered field, so the enables are glitch-free.
module rsc_pin_ctrl #(
    parameter int NUM_SYNC = 3
) (
    input  logic                rst_int_n,
    input  logic                master,
    output logic [NUM_SYNC-1:0] sync_oe,
    output logic                csync_oe,
    output logic                vsout_oe,
    output logic                ttx_oe,
    output logic                phase_oe
);

    // One enable per sync pin, gated by reset and master mode.
    generate
        for (genvar i = 0; i < NUM_SYNC; i++) begin : g_sync_oe
            assign sync_oe[i] = rst_int_n & master;
        end
    endgenerate

    // Fixed-direction outputs released after the reset window.
    assign csync_oe = rst_int_n;
    assign vsout_oe = rst_int_n;
    assign ttx_oe   = rst_int_n;
    assign phase_oe = 1'b0;

endmodule

// File: rtl/rst_strap_ctrl.sv
// Module: top of the reset qualifier and strap configuration unit.
// Ties together the reset stretcher, the configuration registers and the
// pin direction control, and flattens the configuration onto ports.
// Assumes: a single clock domain; straps are static around reset release.
module rst_strap_ctrl
    import rsc_pkg::*;
#(
    parameter int MIN_LOW     = 2,
    parameter int STRETCH     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 2,
    parameter int NUM_SYNC    = 3
) (
    input  logic              clk,
    input  logic              rst_n_raw,
    input  logic              strap_std,
    input  logic              strap_fmt,
    input  logic              strap_ph_lsb,
    input  logic              strap_ph_msb,
    input  logic              strap_master,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_int_n,
    output logic              bus_abort,
    output logic              cfg_std,
    output logic [1:0]        cfg_fmt,
    output logic [1:0]        cfg_phase,
    output logic              cfg_master,
    output logic              cfg_cbar_en,
    output logic [NUM_SYNC-1:0] sync_oe,
    output logic              csync_oe,
    output logic              vsout_oe,
    output logic              ttx_oe,
    output logic              phase_oe
);

    logic               load_cfg;
    logic [STRAP_W-1:0] strap_raw;
    cfg_t               cfg;

    // Pack straps in the bit order fixed by the package.
    always_comb begin
        strap_raw            = '0;
        strap_raw[SB_STD]    = strap_std;
        strap_raw[SB_FMT]    = strap_fmt;
        strap_raw[SB_PH_LSB] = strap_ph_lsb;
        strap_raw[SB_PH_MSB] = strap_ph_msb;
        strap_raw[SB_MASTER] = strap_master;
    end

    rsc_reset_qual #(
        .MIN_LOW (MIN_LOW),
        .STRETCH (STRETCH)
    ) u_qual (
        .clk       (clk),
        .rst_n_raw (rst_n_raw),
        .rst_int_n (rst_int_n),
        .load_cfg  (load_cfg),
        .bus_abort (bus_abort)
    );

    rsc_cfg_regs #(
        .SYNC_STAGES (SYNC_STAGES),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_int_n (rst_int_n),
        .load_cfg  (load_cfg),
        .strap_raw (strap_raw),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg       (cfg)
    );

    rsc_pin_ctrl #(
        .NUM_SYNC (NUM_SYNC)
    ) u_pins (
        .rst_int_n (rst_int_n),
        .master    (cfg.master),
        .sync_oe   (sync_oe),
        .csync_oe  (csync_oe),
        .vsout_oe  (vsout_oe),
        .ttx_oe    (ttx_oe),
        .phase_oe  (phase_oe)
    );

    // Flatten the configuration struct onto output ports.
    assign cfg_std     = cfg.std;
    assign cfg_fmt     = cfg.fmt;
    assign cfg_phase   = cfg.phase;
    assign cfg_master  = cfg.master;
    assign cfg_cbar_en = cfg.cbar_en;

endmodule

// File: rtl/rsc_checker.sv
// Module: property checker bound to rst_strap_ctrl.
// Arms itself on the first internal reset, so nothing is checked on the
// undefined state before the first qualified reset.
module rsc_checker #(
    parameter int NUM_SYNC = 3
) (
    input logic                clk,
    input logic                rst_n_raw,
    input logic                wr_en,
    input logic                rst_int_n,
    input logic                bus_abort,
    input logic                cfg_std,
    input logic [1:0]          cfg_fmt,
    input logic [1:0]          cfg_phase,
    input logic                cfg_master,
    input logic                cfg_cbar_en,
    input logic [NUM_SYNC-1:0] sync_oe,
    input logic                csync_oe,
    input logic                vsout_oe,
    input logic                ttx_oe,
    input logic                phase_oe
);

    logic       armed = 1'b0;
    logic [6:0] fields;

    // Become armed once a qualified reset has been seen.
    always_ff @(posedge clk) begin
        armed <= armed | ~rst_int_n;
    end

    assign fields = {cfg_std, cfg_fmt, cfg_phase, cfg_master, cfg_cbar_en};

    AST_SAFE_PINS: assert property (@(posedge clk) disable iff (!armed)
        !rst_int_n |-> (sync_oe == '0 && !csync_oe && !vsout_oe && !ttx_oe && !phase_oe)); // R4

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!armed)
        bus_abort |=> !bus_abort); // R3

    AST_SHORT_LOW_IGNORED: assert property (@(posedge clk) disable iff (!armed)
        (rst_int_n && !rst_n_raw && $past(rst_n_raw)) |=> rst_int_n); // R1

    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!armed)
        (!rst_int_n ##1 !rst_int_n) |-> $stable(fields)); // R10

    AST_SLAVE_NO_SYNC: assert property (@(posedge clk) disable iff (!armed)
        (rst_int_n && !cfg_master) |-> (sync_oe == '0)); // R8

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!armed)
        (rst_int_n && $past(rst_int_n) && !$past(wr_en)) |-> $stable(fields)); // R11

endmodule

bind rst_strap_ctrl rsc_checker #(.NUM_SYNC(NUM_SYNC)) u_chk (
    .clk         (clk),
    .rst_n_raw   (rst_n_raw),
    .wr_en       (wr_en),
    .rst_int_n   (rst_int_n),
    .bus_abort   (bus_abort),
    .cfg_std     (cfg_std),
    .cfg_fmt     (cfg_fmt),
    .cfg_phase   (cfg_phase),
    .cfg_master  (cfg_master),
    .cfg_cbar_en (cfg_cbar_en),
    .sync_oe     (sync_oe),
    .csync_oe    (csync_oe),
    .vsout_oe    (vsout_oe),
    .ttx_oe      (ttx_oe),
    .phase_oe    (phase_oe)
);

// File: tb/sim_rst_strap_ctrl.sv
`timescale 1ns/1ps
module sim_rst_strap_ctrl;

    logic       clk = 1'b0;
    logic       rst_n_raw = 1'b0;
    logic       strap_std = 1'b0, strap_fmt = 1'b0, strap_ph_lsb = 1'b0;
    logic       strap_ph_msb = 1'b0, strap_master = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [1:0] wr_data = '0;
    logic       rst_int_n, bus_abort, cfg_std, cfg_master, cfg_cbar_en;
    logic [1:0] cfg_fmt, cfg_phase;
    logic [2:0] sync_oe;
    logic       csync_oe, vsout_oe, ttx_oe, phase_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rst_strap_ctrl u0 (
        .clk(clk), .rst_n_raw(rst_n_raw),
        .strap_std(strap_std), .strap_fmt(strap_fmt),
        .strap_ph_lsb(strap_ph_lsb), .strap_ph_msb(strap_ph_msb),
        .strap_master(strap_master),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rst_int_n(rst_int_n), .bus_abort(bus_abort),
        .cfg_std(cfg_std), .cfg_fmt(cfg_fmt), .cfg_phase(cfg_phase),
        .cfg_master(cfg_master), .cfg_cbar_en(cfg_cbar_en),
        .sync_oe(sync_oe), .csync_oe(csync_oe), .vsout_oe(vsout_oe),
        .ttx_oe(ttx_oe), .phase_oe(phase_oe)
    );

    // Behavioural reference model
    int m_st = -1;          // -1 unknown, 0 run, 1 holding low, 2 stretching
    int m_cnt = 0;
    bit m_prev_low = 0, m_prev_known = 0;
    int strap_q[$];
    bit f_known = 0;
    int f_std, f_fmt, f_phase, f_master, f_cbar;
    bit m_abort = 0, ab_known = 0;

    always @(posedge clk) begin
        bit q, ld, wr;
        int s;
        q  = !rst_n_raw && m_prev_known && m_prev_low;
        ld = (m_st == 2) && (m_cnt == 31) && !q;
        wr = (m_st == 0) && wr_en;
        if (ld) begin
            s = strap_q[0];
            f_std = s & 1;
            f_fmt = ((s >> 1) & 1) ? 3 : 0;
            f_phase = (s >> 2) & 3;
            f_master = (s >> 4) & 1;
            f_cbar = 1 - f_master;
            f_known = 1;
        end else if (wr) begin
            case (wr_addr)
                0: f_std = wr_data[0];
                1: f_fmt = wr_data;
                2: f_phase = wr_data;
                3: begin f_master = wr_data[0]; f_cbar = wr_data[1]; end
                default: ;
            endcase
        end
        ab_known = (m_st != -1);
        if (q) begin
            m_abort = (m_st != 1);
            m_st = 1;
            m_cnt = 0;
        end else begin
            m_abort = 0;
            if (m_st == 1 && rst_n_raw) begin m_st = 2; m_cnt = 0; end
            else if (m_st == 2) begin
                if (m_cnt == 31) m_st = 0; else m_cnt++;
            end
        end
        m_prev_low = !rst_n_raw;
        m_prev_known = 1;
        strap_q.push_back({strap_master, strap_ph_msb, strap_ph_lsb, strap_fmt, strap_std});
        if (strap_q.size() > 2) void'(strap_q.pop_front());
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        bit run;
        if (m_st != -1) begin
            run = (m_st == 0);
            chk("R2", "rst_int_n", int'(rst_int_n), int'(run));
            if (ab_known) chk("R3", "bus_abort", int'(bus_abort), int'(m_abort));
            chk("R4", "csync_oe", int'(csync_oe), int'(run));
            chk("R4", "vsout_oe", int'(vsout_oe), int'(run));
            chk("R4", "ttx_oe", int'(ttx_oe), int'(run));
            chk("R4", "phase_oe", int'(phase_oe), 0);
            if (!run) chk("R4", "sync_oe", int'(sync_oe), 0);
            if (f_known) begin
                if (run) chk("R8", "sync_oe", int'(sync_oe), f_master ? 7 : 0);
                chk("R5", "cfg_std", int'(cfg_std), f_std);
                chk("R6", "cfg_fmt", int'(cfg_fmt), f_fmt);
                chk("R7", "cfg_phase", int'(cfg_phase), f_phase);
                chk("R8", "cfg_master", int'(cfg_master), f_master);
                chk("R8", "cfg_cbar_en", int'(cfg_cbar_en), f_cbar);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_straps(input logic [4:0] v);
        {strap_master, strap_ph_msb, strap_ph_lsb, strap_fmt, strap_std} = v;
    endtask

    task automatic do_write(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 2'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_reset(input int low_cycles);
        @(negedge clk);
        rst_n_raw = 1'b0;
        wait_cyc(low_cycles);
        rst_n_raw = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL R2 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // Reset state with PAL, YCbCr, phase lsb=1, master (R5, R6, R7, R8)
        set_straps(5'b10101);
        wait_cyc(4);
        rst_n_raw = 1'b1;
        wait_cyc(40);
        // R9: register writes override straps, including an unmapped address
        do_write(0, 0);
        do_write(1, 2);
        do_write(2, 3);
        do_write(3, 2'b10);
        do_write(5, 3);
        wait_cyc(4);
        // R11: strap changes outside reset are ignored
        set_straps(5'b01010);
        wait_cyc(10);
        // R1: single-cycle low pulse is ignored
        pulse_reset(1);
        wait_cyc(6);
        // R10: writes during hold and stretch are dropped
        @(negedge clk);
        rst_n_raw = 1'b0;
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 2'd1;
        wait_cyc(3);
        rst_n_raw = 1'b1;
        wr_addr = 4'd3; wr_data = 2'd1;
        wait_cyc(20);
        wr_en = 1'b0;
        wait_cyc(20);
        // R2: reset re-qualified in the middle of the stretch restarts it
        set_straps(5'b11011);
        pulse_reset(3);
        wait_cyc(10);
        pulse_reset(2);
        wait_cyc(45);
        do_write(2, 1);
        wait_cyc(3);
        // Long hold, slave straps, then writes after release
        set_straps(5'b00100);
        pulse_reset(12);
        wait_cyc(40);
        do_write(3, 1);
        wait_cyc(5);
        finish_run();
    end

endmodule